// File: doc/BRIEF.md
# Correlated Double Sampling Frame Subtractor

This block takes a raster stream of digitized pixel samples from one sensor sector and turns it into correlated-double-sampled values. It keeps one sample per pixel of the previous frame in a circular frame buffer, which is modelled inside the block as synchronous RAM. The buffer follows the raster scan. Each cycle that carries a sample does three things in one clock: it reads the stored sample at the current pixel address, subtracts that value from the new sample, and writes the new sample back to the same location. The difference is clamped to 8 bits.

A per-pixel mask marks hot pixels. A masked pixel produces a zero output, but its buffer location is still updated. The mask is loaded through a separate write port. A frame-start marker realigns the pixel address with the raster. Each output carries the pixel address it belongs to.

The full sector is 640 pixels per row by 320 rows, set through parameters. The defaults are smaller so that the buffer stays compact in simulation.

Top module: `cds_frame_sub`

## Requirements
- R1: Each accepted sample (smp_valid_i high) takes the current pixel address, and that address is reported on cds_addr_o. The address advances by one per accepted sample and wraps from ROW_PIX*ROWS-1 to 0.
- R2: An accepted sample with frame_start_i high is assigned to address 0. The sample that follows it goes to address 1.
- R3: For an unmasked pixel, cds_data_o is the new sample minus the stored sample. A negative result is output as 0.
- R4: A difference greater than 255 is output as 255.
- R5: Every accepted sample, masked or not, is written to its address. The next visit to that address subtracts it.
- R6: After reset, cds_valid_o stays low until a sample at address ROW_PIX*ROWS-1 has been accepted. Only samples after that one are output as valid.
- R7: A pixel whose mask bit is 1 outputs 0 with cds_valid_o high.
- R8: A mask write in the same cycle as a sample at the same address does not affect that sample. The new mask bit applies from the next visit.
- R9: A cycle without smp_valid_i gives cds_valid_o low in the next cycle. It leaves the buffer and the address counter unchanged.
- R10: Results appear one clock after the sample is presented.
- R11: After reset, cds_valid_o is 0 and the first accepted sample takes address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | IN_W | Digitized pixel sample |
| frame_start_i | input | 1 | Current sample is pixel 0 of a frame |
| mask_we_i | input | 1 | Hot-pixel mask write enable |
| mask_addr_i | input | $clog2(ROW_PIX*ROWS) | Mask write address |
| mask_bit_i | input | 1 | Mask value, 1 = hot pixel |
| cds_valid_o | output | 1 | Output valid |
| cds_data_o | output | 8 | Clamped difference |
| cds_addr_o | output | $clog2(ROW_PIX*ROWS) | Pixel address of the output |

## Verification
Two functions can fall in the same cycle: a mask load and a sample at the same pixel address. The bench provokes this by writing a 1 to the mask of a pixel while that pixel's sample is being presented. The result must be unmasked in that frame and zero in the next. A second coincidence is tested by asserting frame_start_i in the middle of a frame, and also together with the natural wrap; in both cases the address must be forced to 0. A behavioural reference model is compared with the outputs on every clock.

// File: rtl/cds_pkg.sv
package cds_pkg;
  parameter int unsigned CDS_W = 8;
  parameter int unsigned CDS_MAX = (1 << CDS_W) - 1;
  typedef logic [CDS_W-1:0] cds_t;
endpackage

// File: rtl/cds_ram.sv
module cds_ram #(
  parameter int unsigned W  = 10,
  parameter int unsigned D  = 2048,
  localparam int unsigned AW = $clog2(D)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [D];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read sees the old word on a same-address write
  assign rdata_o = mem_q[raddr_i];

  AST_WADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < D)) else $error("ram write out of range"); // R1
endmodule

// File: rtl/cds_addr_gen.sv
module cds_addr_gen #(
  parameter int unsigned FRAME = 2048,
  localparam int unsigned AW = $clog2(FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          restart_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          primed_o
);
  localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

  logic [AW-1:0] addr_q;
  logic          primed_q;

  assign cur_addr_o = restart_i ? '0 : addr_q;
  assign primed_o   = primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      primed_q <= 1'b0;
    end else if (adv_i) begin
      addr_q <= (cur_addr_o == LAST) ? '0 : cur_addr_o + 1'b1;
      if (cur_addr_o == LAST) primed_q <= 1'b1;
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(addr_q) < FRAME) else $error("address out of frame"); // R1
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !restart_i && addr_q == LAST) |=> addr_q == '0) else $error("no wrap"); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(addr_q)) else $error("address moved while idle"); // R9
endmodule

// File: rtl/cds_sub_sat.sv
module cds_sub_sat
  import cds_pkg::*;
#(
  parameter int unsigned IN_W = 10
) (
  input  logic [IN_W-1:0] new_i,
  input  logic [IN_W-1:0] old_i,
  input  logic            mask_i,
  output cds_t            res_o
);
  logic signed [IN_W:0] diff;
  cds_t                 clamped;

  assign diff = $signed({1'b0, new_i}) - $signed({1'b0, old_i});

  generate
    if (IN_W > CDS_W) begin : g_clamp_hi
      always_comb begin
        if (diff < 0)                                clamped = '0;
        else if (diff > $signed((IN_W+1)'(CDS_MAX)))  clamped = cds_t'(CDS_MAX);
        else                                         clamped = diff[CDS_W-1:0];
      end
    end else begin : g_clamp_lo
      always_comb begin
        if (diff < 0) clamped = '0;
        else          clamped = CDS_W'(diff[IN_W-1:0]);
      end
    end
  endgenerate

  assign res_o = mask_i ? '0 : clamped;
endmodule

// File: rtl/cds_frame_sub.sv
module cds_frame_sub
  import cds_pkg::*;
#(
  parameter int unsigned IN_W    = 10,
  parameter int unsigned ROW_PIX = 64,
  parameter int unsigned ROWS    = 32,
  localparam int unsigned FRAME  = ROW_PIX * ROWS,
  localparam int unsigned AW     = $clog2(FRAME)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            smp_valid_i,
  input  logic [IN_W-1:0] smp_data_i,
  input  logic            frame_start_i,
  input  logic            mask_we_i,
  input  logic [AW-1:0]   mask_addr_i,
  input  logic            mask_bit_i,
  output logic            cds_valid_o,
  output logic [CDS_W-1:0] cds_data_o,
  output logic [AW-1:0]   cds_addr_o
);
  logic [AW-1:0]   cur_addr;
  logic            primed;
  logic [IN_W-1:0] old_smp;
  logic            hot;
  cds_t            res;

  cds_addr_gen #(.FRAME(FRAME)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (smp_valid_i),
    .restart_i  (frame_start_i),
    .cur_addr_o (cur_addr),
    .primed_o   (primed)
  );

  cds_ram #(.W(IN_W), .D(FRAME)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (smp_valid_i),
    .waddr_i (cur_addr),
    .wdata_i (smp_data_i),
    .raddr_i (cur_addr),
    .rdata_o (old_smp)
  );

  cds_ram #(.W(1), .D(FRAME)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .waddr_i (mask_addr_i),
    .wdata_i (mask_bit_i),
    .raddr_i (cur_addr),
    .rdata_o (hot)
  );

  cds_sub_sat #(.IN_W(IN_W)) u_sub (
    .new_i  (smp_data_i),
    .old_i  (old_smp),
    .mask_i (hot),
    .res_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cds_valid_o <= 1'b0;
      cds_data_o  <= '0;
      cds_addr_o  <= '0;
    end else begin
      cds_valid_o <= smp_valid_i && primed;
      if (smp_valid_i) begin
        cds_data_o <= res;
        cds_addr_o <= cur_addr;
      end
    end
  end

  AST_FIRST_FRAME_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |=> !cds_valid_o) else $error("valid before first frame"); // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !cds_valid_o) else $error("valid without sample"); // R9
  AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && hot) |=> cds_data_o == '0) else $error("hot pixel leaked"); // R7
  AST_FS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && frame_start_i) |=> cds_addr_o == '0) else $error("frame start addr"); // R2
  AST_NEG_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_data_i < old_smp) |=> cds_data_o == '0) else $error("negative leaked"); // R3
endmodule

// File: tb/sim_cds_frame_sub.sv
module sim_cds_frame_sub;
  localparam int IN_W = 10;
  localparam int ROW_PIX = 8;
  localparam int ROWS = 4;
  localparam int FRAME = ROW_PIX * ROWS;
  localparam int AW = $clog2(FRAME);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [IN_W-1:0] smp_data_i = '0;
  logic frame_start_i = 1'b0;
  logic mask_we_i = 1'b0;
  logic [AW-1:0] mask_addr_i = '0;
  logic mask_bit_i = 1'b0;
  logic cds_valid_o;
  logic [7:0] cds_data_o;
  logic [AW-1:0] cds_addr_o;

  always #5 clk_i = ~clk_i;

  cds_frame_sub #(.IN_W(IN_W), .ROW_PIX(ROW_PIX), .ROWS(ROWS)) u0 (.*);

  int checks = 0, errors = 0;
  int ref_buf [FRAME];
  bit ref_mask [FRAME];
  int ref_addr = 0;
  bit ref_primed = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive on negedge, compare one edge later (R10)
  task automatic step(bit v, int d, bit fs, bit mwe, int ma, bit mb, string tag);
    int a, ed;
    bit ev;
    @(negedge clk_i);
    smp_valid_i = v; smp_data_i = IN_W'(d); frame_start_i = fs;
    mask_we_i = mwe; mask_addr_i = AW'(ma); mask_bit_i = mb;
    a = fs ? 0 : ref_addr;
    ev = v && ref_primed;
    ed = 0;
    if (v) begin
      if (ref_mask[a]) ed = 0;
      else begin
        ed = d - ref_buf[a];
        if (ed < 0) ed = 0;
        if (ed > 255) ed = 255;
      end
      ref_buf[a] = d;
      if (a == FRAME-1) ref_primed = 1;
      ref_addr = (a == FRAME-1) ? 0 : a + 1;
    end
    if (mwe) ref_mask[ma] = mb;
    @(posedge clk_i); #1;
    chk({tag, " valid"}, int'(cds_valid_o), int'(ev));
    if (ev) begin
      chk({tag, " data R10"}, int'(cds_data_o), ed);
      chk(fs ? "R2 addr" : "R1 addr", int'(cds_addr_o), a);
    end
  endtask

  initial begin
    #(200000*10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < FRAME; i++) begin ref_buf[i] = 0; ref_mask[i] = 0; end
    #22 rst_ni = 1'b1;
    #1 chk("R11 reset valid", int'(cds_valid_o), 0);
    // clear mask, no samples: R9
    for (int i = 0; i < FRAME; i++) step(0, 0, 0, 1, i, 0, "R9");
    // first frame quiet: R6, starts at address 0: R11
    for (int i = 0; i < FRAME; i++) step(1, (i*53) % 1024, i == 0, 0, 0, 0, "R6");
    // frame with mixed differences: R3 R4 R5, idle gaps R9
    for (int i = 0; i < FRAME; i++) begin
      step(1, (i*389 + 700) % 1024, 0, 0, 0, 0, (i % 2) ? "R4" : "R3");
      if (i % 7 == 3) step(0, 1023, 0, 0, 0, 0, "R9");
    end
    // set hot pixel 5 and collide mask load with sample at 7: R7 R8
    step(0, 0, 0, 1, 5, 1, "R7");
    for (int i = 0; i < FRAME; i++)
      step(1, (i*211 + 13) % 1024, 0, i == 7, 7, 1, (i == 7) ? "R8" : "R5");
    for (int i = 0; i < FRAME; i++)
      step(1, (i*97 + 500) % 1024, 0, 0, 0, 0, (i == 5 || i == 7) ? "R7" : "R5");
    // restart mid-frame: R2
    for (int i = 0; i < 10; i++) step(1, (i*300) % 1024, 0, 0, 0, 0, "R1");
    for (int i = 0; i < FRAME + 4; i++)
      step(1, (i*451 + 77) % 1024, i == 0 || i == FRAME, 0, 0, 0, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule